// File: doc/BRIEF.md
# Serial Management Slave with Two-Register Map

This block is the management end of a fast Ethernet physical layer. A station manager clocks frames in over a slow serial clock and a single bidirectional data line. The block recognises read and write frames aimed at its five-bit address, which is strapped on static inputs. It keeps a small control register whose bits steer the rest of the port: loopback, power-down and a self-clearing soft reset. It answers reads of a status register that reports fixed capabilities and a link flag. That flag latches low on any loss of link and holds low until software reads it.

The serial clock is slow and unrelated to the system clock. The block oversamples both serial lines through a synchroniser and acts on each detected rising edge of the serial clock. The data line is split into an input, an output and an output enable, so a pad cell can be placed outside the block.

Top module: `mgmt_serial_slave`

## Requirements
- R1: After reset, mdio_oe_o, loopback_o, power_down_o and soft_reset_o are all 0.
- R2: A write to register 0 with a matching PHY address sets loopback_o from data bit 14 and power_down_o from data bit 11. A later read of register 0 returns both bits at those positions.
- R3: A read of register 0 returns 1 in bit 13 and 0 in bits 15, 12 and 10 to 0, whatever was written to those bits.
- R4: A write of register 0 with bit 15 set pulses soft_reset_o high for exactly one clock. It clears loopback and power-down and clears the link latch, ignoring the other data bits.
- R5: A read of register 1 returns 1 in bit 13, the link latch in bit 2, and 0 in every other bit.
- R6: The link latch goes to 0 whenever link_up_i is low. It stays 0 after the link returns, until register 1 is read. That read returns the latched value and then reloads the latch from link_up_i. The latch is 0 out of reset.
- R7: Reads of register addresses other than 0 and 1 return 0. Writes to any address other than 0 change no register.
- R8: A frame whose PHY address differs from phy_addr_i changes no register, and mdio_oe_o stays 0 throughout it.
- R9: On a matching read, mdio_oe_o stays 0 during the first turnaround bit. The slave drives 0 during the second turnaround bit, then 16 data bits MSB first, and releases the line after the last data bit.
- R10: A frame counts only if at least 32 consecutive ones precede the start pattern 0,1, and only if its opcode is 1,0 (read) or 0,1 (write). Otherwise it has no effect.
- R11: mdio_i is taken at the rising edge of mdc_i. A change of mdio_i while mdc_i is high has no effect, and mdio_o and mdio_oe_o change only just after a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_i | input | 1 | Serial management clock |
| mdio_i | input | 1 | Serial data from the line |
| mdio_o | output | 1 | Serial data to the line |
| mdio_oe_o | output | 1 | Drive enable for mdio_o |
| phy_addr_i | input | 5 | Strapped PHY address |
| link_up_i | input | 1 | Current link indication, synchronous to clk |
| loopback_o | output | 1 | Loopback enable from the control register |
| power_down_o | output | 1 | Power-down enable from the control register |
| soft_reset_o | output | 1 | One-clock pulse on a software reset |

## Verification
A corrupt shift register or bit counter shows up in the very next read frame. The turnaround bits come out misplaced, the data is shifted by a bit, or the line is not released after bit 0, and all of this is visible within a single serial bit time. A corrupt control register shows on loopback_o or power_down_o a few system clocks after the write frame ends. A stuck link latch shows only when register 1 is read, so the reads are placed around link drops and recoveries to expose it.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;

    localparam int unsigned REG_W  = 16;
    localparam int unsigned ADDR_W = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_OP_A,
        ST_OP_B,
        ST_PHY,
        ST_REG,
        ST_TA1,
        ST_TA2,
        ST_DATA
    } frame_st_e;

    localparam logic [1:0] OPC_RD = 2'b10;
    localparam logic [1:0] OPC_WR = 2'b01;

    localparam logic [ADDR_W-1:0] RA_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] RA_STAT = 5'd1;

    localparam int unsigned CTRL_RST_BIT  = 15;
    localparam int unsigned CTRL_LB_BIT   = 14;
    localparam int unsigned CTRL_SPD_BIT  = 13;
    localparam int unsigned CTRL_PD_BIT   = 11;
    localparam int unsigned STAT_HD_BIT   = 13;
    localparam int unsigned STAT_LINK_BIT = 2;

endpackage

// File: rtl/mgmt_edge_sync.sv
`timescale 1ns/1ps
module mgmt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic mdc_rise_o,
    output logic mdio_bit_o
);

    typedef struct packed {
        logic [STAGES-1:0] mdc;
        logic [STAGES-1:0] mdio;
        logic              mdc_last;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.mdc      = (s_q.mdc << 1) | STAGES'(mdc_i);
        s_d.mdio     = (s_q.mdio << 1) | STAGES'(mdio_i);
        s_d.mdc_last = s_q.mdc[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc_rise_o = s_q.mdc[STAGES-1] & ~s_q.mdc_last;
    assign mdio_bit_o = s_q.mdio[STAGES-1];

    // R11
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdc_rise_o |=> !mdc_rise_o);

endmodule

// File: rtl/mgmt_frame_engine.sv
`timescale 1ns/1ps
module mgmt_frame_engine
    import mgmt_pkg::*;
#(
    parameter int unsigned PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb_i,
    input  logic              bit_val_i,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic [REG_W-1:0]  rd_data_i,
    output logic              rd_stb_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_stb_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [REG_W-1:0]  wr_data_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);

    localparam int unsigned CNT_W = $clog2(PRE_LEN + 1);
    localparam int unsigned BC_W  = $clog2(REG_W);

    typedef struct packed {
        frame_st_e         st;
        logic [CNT_W-1:0]  pre_cnt;
        logic              is_rd;
        logic              op_hi;
        logic              phy_ok;
        logic [ADDR_W-1:0] reg_addr;
        logic [BC_W-1:0]   bcnt;
        logic [REG_W-1:0]  sh;
        logic              oe;
        logic              dout;
    } eng_t;

    eng_t f_d, f_q;
    logic [ADDR_W-1:0] field;
    logic              answer;

    assign field  = {f_q.sh[ADDR_W-2:0], bit_val_i};
    assign answer = f_q.is_rd & f_q.phy_ok;

    always_comb begin
        f_d       = f_q;
        rd_stb_o  = 1'b0;
        wr_stb_o  = 1'b0;
        rd_addr_o = field;
        wr_addr_o = f_q.reg_addr;
        wr_data_o = {f_q.sh[REG_W-2:0], bit_val_i};
        if (bit_stb_i) begin
            unique case (f_q.st)
                ST_IDLE: begin
                    if (bit_val_i) begin
                        if (f_q.pre_cnt != CNT_W'(PRE_LEN))
                            f_d.pre_cnt = f_q.pre_cnt + 1'b1;
                    end else begin
                        if (f_q.pre_cnt == CNT_W'(PRE_LEN))
                            f_d.st = ST_START;
                        f_d.pre_cnt = '0;
                    end
                end
                ST_START: f_d.st = bit_val_i ? ST_OP_A : ST_IDLE;
                ST_OP_A: begin
                    f_d.op_hi = bit_val_i;
                    f_d.st    = ST_OP_B;
                end
                ST_OP_B: begin
                    f_d.bcnt = '0;
                    if ({f_q.op_hi, bit_val_i} == OPC_RD) begin
                        f_d.is_rd = 1'b1;
                        f_d.st    = ST_PHY;
                    end else if ({f_q.op_hi, bit_val_i} == OPC_WR) begin
                        f_d.is_rd = 1'b0;
                        f_d.st    = ST_PHY;
                    end else begin
                        f_d.st = ST_IDLE;
                    end
                end
                ST_PHY: begin
                    f_d.sh = {f_q.sh[REG_W-2:0], bit_val_i};
                    if (f_q.bcnt == BC_W'(ADDR_W - 1)) begin
                        f_d.phy_ok = (field == phy_addr_i);
                        f_d.bcnt   = '0;
                        f_d.st     = ST_REG;
                    end else begin
                        f_d.bcnt = f_q.bcnt + 1'b1;
                    end
                end
                ST_REG: begin
                    f_d.sh = {f_q.sh[REG_W-2:0], bit_val_i};
                    if (f_q.bcnt == BC_W'(ADDR_W - 1)) begin
                        f_d.reg_addr = field;
                        f_d.bcnt     = '0;
                        f_d.st       = ST_TA1;
                        if (answer) begin
                            rd_stb_o = 1'b1;
                            f_d.sh   = rd_data_i;
                        end
                    end else begin
                        f_d.bcnt = f_q.bcnt + 1'b1;
                    end
                end
                ST_TA1: begin
                    f_d.st = ST_TA2;
                    if (answer) begin
                        f_d.oe   = 1'b1;
                        f_d.dout = 1'b0;
                    end
                end
                ST_TA2: begin
                    f_d.st   = ST_DATA;
                    f_d.bcnt = '0;
                    if (answer) begin
                        f_d.dout = f_q.sh[REG_W-1];
                        f_d.sh   = f_q.sh << 1;
                    end
                end
                ST_DATA: begin
                    if (f_q.bcnt == BC_W'(REG_W - 1)) begin
                        f_d.st      = ST_IDLE;
                        f_d.pre_cnt = '0;
                        f_d.oe      = 1'b0;
                        f_d.dout    = 1'b0;
                        wr_stb_o    = ~f_q.is_rd & f_q.phy_ok;
                    end else begin
                        f_d.bcnt = f_q.bcnt + 1'b1;
                        if (f_q.is_rd) begin
                            if (f_q.oe) f_d.dout = f_q.sh[REG_W-1];
                            f_d.sh = f_q.sh << 1;
                        end else begin
                            f_d.sh = {f_q.sh[REG_W-2:0], bit_val_i};
                        end
                    end
                end
                default: f_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign mdio_o    = f_q.dout;
    assign mdio_oe_o = f_q.oe;

    // R9
    ta_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe_o) |-> !mdio_o);

    // R11
    oe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe_o) |-> $past(bit_stb_i));

    // R8
    no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb_o && wr_stb_o));

endmodule

// File: rtl/mgmt_reg_bank.sv
`timescale 1ns/1ps
module mgmt_reg_bank
    import mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_up_i,
    input  logic              rd_stb_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              wr_stb_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              loopback_o,
    output logic              power_down_o,
    output logic              soft_reset_o
);

    typedef struct packed {
        logic lb;
        logic pd;
        logic link_lat;
        logic srst;
    } bank_t;

    bank_t b_d, b_q;
    logic [REG_W-1:0] ctrl_word, stat_word;
    logic unused_bits;

    assign unused_bits = ^{wr_data_i[13:12], wr_data_i[10:0]};

    always_comb begin
        ctrl_word                = '0;
        ctrl_word[CTRL_LB_BIT]   = b_q.lb;
        ctrl_word[CTRL_SPD_BIT]  = 1'b1;
        ctrl_word[CTRL_PD_BIT]   = b_q.pd;
        stat_word                = '0;
        stat_word[STAT_HD_BIT]   = 1'b1;
        stat_word[STAT_LINK_BIT] = b_q.link_lat;
        case (rd_addr_i)
            RA_CTRL: rd_data_o = ctrl_word;
            RA_STAT: rd_data_o = stat_word;
            default: rd_data_o = '0;
        endcase
    end

    always_comb begin
        b_d      = b_q;
        b_d.srst = 1'b0;
        if (!link_up_i) b_d.link_lat = 1'b0;
        if (rd_stb_i && rd_addr_i == RA_STAT) b_d.link_lat = link_up_i;
        if (wr_stb_i && wr_addr_i == RA_CTRL) begin
            if (wr_data_i[CTRL_RST_BIT]) begin
                b_d.lb       = 1'b0;
                b_d.pd       = 1'b0;
                b_d.link_lat = 1'b0;
                b_d.srst     = 1'b1;
            end else begin
                b_d.lb = wr_data_i[CTRL_LB_BIT];
                b_d.pd = wr_data_i[CTRL_PD_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign loopback_o   = b_q.lb;
    assign power_down_o = b_q.pd;
    assign soft_reset_o = b_q.srst;

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_o |=> !soft_reset_o);

    // R4
    reset_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_o |-> (!loopback_o && !power_down_o && !b_q.link_lat));

    // R6
    latch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up_i |=> !b_q.link_lat);

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(b_q.link_lat) |-> $past(rd_stb_i && rd_addr_i == RA_STAT));

endmodule

// File: rtl/mgmt_serial_slave.sv
`timescale 1ns/1ps
module mgmt_serial_slave
    import mgmt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PRE_LEN     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_i,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic [ADDR_W-1:0] phy_addr_i,
    input  logic              link_up_i,
    output logic              loopback_o,
    output logic              power_down_o,
    output logic              soft_reset_o
);

    logic              bit_stb, bit_val;
    logic              rd_stb, wr_stb;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [REG_W-1:0]  wr_data, rd_data;

    mgmt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .mdc_i      (mdc_i),
        .mdio_i     (mdio_i),
        .mdc_rise_o (bit_stb),
        .mdio_bit_o (bit_val)
    );

    mgmt_frame_engine #(.PRE_LEN(PRE_LEN)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_stb_i  (bit_stb),
        .bit_val_i  (bit_val),
        .phy_addr_i (phy_addr_i),
        .rd_data_i  (rd_data),
        .rd_stb_o   (rd_stb),
        .rd_addr_o  (rd_addr),
        .wr_stb_o   (wr_stb),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o)
    );

    mgmt_reg_bank u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .link_up_i    (link_up_i),
        .rd_stb_i     (rd_stb),
        .rd_addr_i    (rd_addr),
        .wr_stb_i     (wr_stb),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .rd_data_o    (rd_data),
        .loopback_o   (loopback_o),
        .power_down_o (power_down_o),
        .soft_reset_o (soft_reset_o)
    );

endmodule

// File: tb/mgmt_serial_slave_bench.sv
`timescale 1ns/1ps
module mgmt_serial_slave_bench;

    localparam int          HALF   = 6;
    localparam logic [4:0]  MY_PHY = 5'h13;

    logic       clk = 1'b0, rst_n = 1'b0, mdc = 1'b0, mdio_in = 1'b0, link_up = 1'b0;
    logic [4:0] phy_addr = MY_PHY;
    logic       mdio_o, mdio_oe, loopback, power_down, soft_reset;

    int  vectors = 0, errors = 0, srst_cycles = 0;
    bit  done = 0, glitch = 0;
    bit  m_lb = 0, m_pd = 0, m_latch = 0;

    always #2.5 clk = ~clk;

    mgmt_serial_slave u_mgmt_serial_slave (
        .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_i(mdio_in),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .phy_addr_i(phy_addr),
        .link_up_i(link_up), .loopback_o(loopback), .power_down_o(power_down),
        .soft_reset_o(soft_reset)
    );

    always @(posedge clk) if (soft_reset === 1'b1) srst_cycles++;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic s_oe, output logic s_out);
        mdc = 1'b0; mdio_in = b;
        repeat (HALF) @(posedge clk);
        #1; s_oe = mdio_oe; s_out = mdio_o;
        mdc = 1'b1;
        repeat (3) @(posedge clk);
        #1; if (glitch) mdio_in = ~b;
        repeat (HALF - 3) @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] model_val(input logic [4:0] ra);
        if (ra == 5'd0) return {1'b0, m_lb, 1'b1, 1'b0, m_pd, 11'b0};
        if (ra == 5'd1) return {3'b001, 10'b0, m_latch, 2'b00};
        return 16'h0;
    endfunction

    task automatic run_frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] wd, input bit rd_mode,
                             input logic [15:0] exp, input bit drive, input string tag);
        logic so, sd, oe_bad;
        logic [15:0] got;
        for (int i = 0; i < pre; i++) send_bit(1'b1, so, sd);
        send_bit(1'b0, so, sd); send_bit(1'b1, so, sd);
        send_bit(op[1], so, sd); send_bit(op[0], so, sd);
        for (int i = 4; i >= 0; i--) send_bit(phy[i], so, sd);
        for (int i = 4; i >= 0; i--) send_bit(ra[i], so, sd);
        if (rd_mode) begin
            send_bit(1'b1, so, sd); chk(tag, "turnaround-1 enable", 32'(so), 0);
            send_bit(1'b1, so, sd); chk(tag, "turnaround-2 enable", 32'(so), 32'(drive));
            if (drive) chk(tag, "turnaround-2 level", 32'(sd), 0);
            got = '0; oe_bad = 1'b0;
            for (int i = 15; i >= 0; i--) begin
                send_bit(1'b1, so, sd);
                got[i] = sd;
                if (so !== drive) oe_bad = 1'b1;
            end
            chk(tag, "enable held over data", 32'(oe_bad), 0);
            if (drive) chk(tag, "read data", 32'(got), 32'(exp));
            send_bit(1'b0, so, sd); chk(tag, "release after data", 32'(so), 0);
        end else begin
            send_bit(1'b1, so, sd); send_bit(1'b0, so, sd);
            for (int i = 15; i >= 0; i--) send_bit(wd[i], so, sd);
            send_bit(1'b0, so, sd);
        end
    endtask

    task automatic wr(input logic [4:0] ra, input logic [15:0] d, input string tag);
        run_frame(32, 2'b01, MY_PHY, ra, d, 0, 16'h0, 0, tag);
        if (ra == 5'd0) begin
            if (d[15]) begin m_lb = 0; m_pd = 0; m_latch = 0; end
            else begin m_lb = d[14]; m_pd = d[11]; end
        end
    endtask

    task automatic rd(input logic [4:0] ra, input string tag);
        run_frame(32, 2'b10, MY_PHY, ra, 16'h0, 1, model_val(ra), 1, tag);
        if (ra == 5'd1) m_latch = link_up;
    endtask

    task automatic ctl_chk(input string tag);
        chk(tag, "loopback_o", 32'(loopback), 32'(m_lb));
        chk(tag, "power_down_o", 32'(power_down), 32'(m_pd));
    endtask

    task automatic set_link(input logic v);
        link_up = v;
        repeat (3) @(posedge clk);
        #1; if (!v) m_latch = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++; errors++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int s0;
        repeat (5) @(posedge clk);
        #1;
        chk("R1", "mdio_oe_o in reset", 32'(mdio_oe), 0);
        chk("R1", "soft_reset_o in reset", 32'(soft_reset), 0);
        ctl_chk("R1");
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1; ctl_chk("R1");

        // R3, R9: default control read
        rd(5'd0, "R3");
        // R2: set both control bits
        wr(5'd0, 16'h4800, "R2"); ctl_chk("R2");
        rd(5'd0, "R2");
        // R3: junk in read-only bits is not kept
        wr(5'd0, 16'h77FF, "R3"); ctl_chk("R3");
        rd(5'd0, "R3");

        // R8: foreign address write and read
        run_frame(32, 2'b01, MY_PHY ^ 5'h01, 5'd0, 16'h0000, 0, 16'h0, 0, "R8");
        ctl_chk("R8");
        run_frame(32, 2'b10, MY_PHY ^ 5'h10, 5'd0, 16'h0, 1, 16'h0, 0, "R8");

        // R5, R6: latch starts low, reloads on read
        rd(5'd1, "R5");
        set_link(1'b1);
        rd(5'd1, "R6");
        rd(5'd1, "R5");
        set_link(1'b0);
        set_link(1'b1);
        rd(5'd1, "R6");
        rd(5'd1, "R6");

        // R7: other addresses
        wr(5'd1, 16'hFFFF, "R7");
        rd(5'd1, "R7");
        rd(5'd7, "R7");
        wr(5'd5, 16'hC800, "R7");
        rd(5'd5, "R7");
        rd(5'd0, "R7"); ctl_chk("R7");

        // R10: short preamble and bad opcodes
        run_frame(31, 2'b01, MY_PHY, 5'd0, 16'h0800, 0, 16'h0, 0, "R10"); ctl_chk("R10");
        run_frame(32, 2'b11, MY_PHY, 5'd0, 16'h0800, 0, 16'h0, 0, "R10"); ctl_chk("R10");
        run_frame(32, 2'b00, MY_PHY, 5'd0, 16'h0800, 0, 16'h0, 0, "R10"); ctl_chk("R10");
        rd(5'd0, "R10");

        // R11: data flips while the clock is high
        glitch = 1;
        wr(5'd0, 16'h0800, "R11");
        glitch = 0;
        ctl_chk("R11");
        rd(5'd0, "R11");

        // R4: soft reset
        wr(5'd0, 16'h4800, "R4"); ctl_chk("R4");
        s0 = srst_cycles;
        wr(5'd0, 16'hC800, "R4");
        chk("R4", "reset pulse length", 32'(srst_cycles - s0), 1);
        ctl_chk("R4");
        rd(5'd0, "R4");
        rd(5'd1, "R4");
        rd(5'd1, "R4");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule